// File: doc/BRIEF.md
# Virtual Alias Conflict Resolver

This block sits beside the directory of an inclusive second-level cache whose upper-level data cache is virtually indexed and physically tagged. With a 64 KB, 4-way upper cache and 4 KB pages, each way spans 16 KB, so two index bits lie above the page offset. The same physical line could therefore occupy any of four sets upstream. The directory keeps, for each line, the two alias bits under which the upper level holds its copy. This resolver makes sure a line is cached upstream under at most one alias at a time.

For each Acquire lookup, the resolver receives the hit flag, the client-present flag, the alias stored in the directory and the alias carried by the request. It then takes one of three paths:

- **Alias matches and a client holds the line.** The grant is allowed in the same cycle.
- **Line missed, or no client holds it.** The new alias is recorded and the grant follows one cycle later.
- **A client holds the line under a different alias.** The resolver first sends a probe addressed to the old alias and waits for the acknowledgement. Only then does it write the new alias and release the grant. A dirty acknowledgement raises a writeback flag alongside that directory write.

The width of the alias field is derived from the cache and page geometry parameters.

Top module: `alias_resolver`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `grant`, `probe_valid`, `dir_wr_valid` and `wb_need` are all 0.
- R2: An accepted request with `req_hit`=1, `req_client`=1 and `dir_alias` equal to `req_alias` raises `grant` in the same cycle. It raises no probe and no directory write.
- R3: An accepted request with `req_hit`=1 and `req_client`=0 sends no probe. In the next cycle it raises `dir_wr_valid` with `dir_wr_alias` equal to the request alias, together with `grant`.
- R4: An accepted request with `req_hit`=0 behaves as in R3: the alias is recorded and the grant follows one cycle later, with no probe.
- R5: An accepted request with `req_hit`=1, `req_client`=1 and differing aliases raises `probe_valid` in the next cycle, with `probe_alias` equal to the stored alias. The probe and its alias are held unchanged until `probe_ready` is 1.
- R6: After the probe is accepted, `grant` and `dir_wr_valid` stay 0 until `ack_valid` is seen. In the cycle after the acknowledgement, `dir_wr_valid` and `grant` are 1 and `dir_wr_alias` equals the new alias.
- R7: `wb_need` equals the `ack_dirty` value that came with the acknowledgement, and is 1 only in the cycle that `dir_wr_valid` is 1.
- R8: While a conflict is being resolved, `req_ready` is 0. A `req_valid` presented in that time is ignored: it causes no grant and no extra activity afterwards.
- R9: An `ack_valid` that arrives while no probe is outstanding is ignored. It does not change state, and a later write on the R3 path has `wb_need`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Acquire lookup result presented |
| req_ready | output | 1 | Resolver idle and able to take a lookup |
| req_hit | input | 1 | Directory hit for the Acquire |
| req_client | input | 1 | Upper level holds a copy of the line |
| dir_alias | input | 2 | Alias recorded in the directory entry |
| req_alias | input | 2 | Alias carried by the Acquire |
| grant | output | 1 | Acquire may proceed to its grant |
| probe_valid | output | 1 | Probe to the upper level pending |
| probe_ready | input | 1 | Probe accepted by the upper level |
| probe_alias | output | 2 | Alias the probe targets |
| ack_valid | input | 1 | Probe acknowledgement received |
| ack_dirty | input | 1 | Acknowledgement carried dirty data |
| dir_wr_valid | output | 1 | Write the alias field of the directory entry |
| dir_wr_alias | output | 2 | Alias value to write |
| wb_need | output | 1 | Probed data is dirty and must be written back |

## Verification
The bench covers four kinds of corner case:

- **Probe stalls of several lengths.** A resolver that let the probe alias drift, or dropped the probe before `probe_ready`, would send the invalidation to the wrong set.
- **A delay between probe acceptance and acknowledgement.** A design that granted on probe acceptance rather than on the acknowledgement would let two aliases coexist upstream.
- **A stray acknowledgement while idle, and a new request during a resolution.** A design that latched either of these would raise a false writeback or start a phantom grant.
- **Clean and dirty acknowledgements, client-absent hits and misses.** These show whether `wb_need` follows the acknowledgement, and whether unnecessary probes are sent.

// File: rtl/alias_resolver_pkg.sv
package alias_resolver_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_UPDATE = 2'd3
    } res_state_e;

    typedef enum logic [1:0] {
        ACT_PASS  = 2'd0,
        ACT_WRITE = 2'd1,
        ACT_PROBE = 2'd2
    } res_action_e;

endpackage

// File: rtl/alias_classify.sv
module alias_classify
    import alias_resolver_pkg::*;
#(
    parameter int ALIAS_W = 2
) (
    input  logic               hit,
    input  logic               client,
    input  logic [ALIAS_W-1:0] stored_alias,
    input  logic [ALIAS_W-1:0] new_alias,
    output res_action_e        action
);

    logic same_alias;

    always_comb begin
        same_alias = (stored_alias == new_alias);
        if (!hit || !client) begin
            action = ACT_WRITE;      // nobody upstream can hold a conflicting copy
        end else if (same_alias) begin
            action = ACT_PASS;
        end else begin
            action = ACT_PROBE;
        end
    end

endmodule

// File: rtl/alias_fsm.sv
module alias_fsm
    import alias_resolver_pkg::*;
#(
    parameter int ALIAS_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  res_action_e        action,
    input  logic [ALIAS_W-1:0] stored_alias,
    input  logic [ALIAS_W-1:0] new_alias,
    input  logic               probe_ready,
    input  logic               ack_valid,
    input  logic               ack_dirty,
    output logic               idle,
    output logic               pass_now,
    output logic               probe_valid,
    output logic [ALIAS_W-1:0] probe_alias,
    output logic               update,
    output logic [ALIAS_W-1:0] update_alias,
    output logic               dirty
);

    typedef struct packed {
        res_state_e         state;
        logic [ALIAS_W-1:0] old_alias;
        logic [ALIAS_W-1:0] nxt_alias;
        logic               dirty;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.dirty = 1'b0;
                if (start && action != ACT_PASS) begin
                    r_d.old_alias = stored_alias;
                    r_d.nxt_alias = new_alias;
                    r_d.state     = (action == ACT_PROBE) ? ST_PROBE : ST_UPDATE;
                end
            end
            ST_PROBE: begin
                if (probe_ready) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (ack_valid) begin
                    r_d.dirty = ack_dirty;
                    r_d.state = ST_UPDATE;
                end
            end
            ST_UPDATE: begin
                r_d.state = ST_IDLE;
                r_d.dirty = 1'b0;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, old_alias: '0, nxt_alias: '0, dirty: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        idle         = (r_q.state == ST_IDLE);
        pass_now     = idle && start && (action == ACT_PASS);
        probe_valid  = (r_q.state == ST_PROBE);
        probe_alias  = r_q.old_alias;
        update       = (r_q.state == ST_UPDATE);
        update_alias = r_q.nxt_alias;
        dirty        = update && r_q.dirty;
    end

endmodule

// File: rtl/alias_resolver.sv
module alias_resolver
    import alias_resolver_pkg::*;
#(
    parameter int L1_BYTES   = 65536,
    parameter int L1_WAYS    = 4,
    parameter int PAGE_BYTES = 4096,
    localparam int WAY_BYTES = L1_BYTES / L1_WAYS,
    localparam int ALIAS_W   = (WAY_BYTES > PAGE_BYTES) ? $clog2(WAY_BYTES / PAGE_BYTES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_hit,
    input  logic               req_client,
    input  logic [ALIAS_W-1:0] dir_alias,
    input  logic [ALIAS_W-1:0] req_alias,
    output logic               grant,
    output logic               probe_valid,
    input  logic               probe_ready,
    output logic [ALIAS_W-1:0] probe_alias,
    input  logic               ack_valid,
    input  logic               ack_dirty,
    output logic               dir_wr_valid,
    output logic [ALIAS_W-1:0] dir_wr_alias,
    output logic               wb_need
);

    res_action_e action;
    logic        idle;
    logic        pass_now;
    logic        update;
    logic        dirty;

    alias_classify #(.ALIAS_W(ALIAS_W)) u_cls (
        .hit          (req_hit),
        .client       (req_client),
        .stored_alias (dir_alias),
        .new_alias    (req_alias),
        .action       (action)
    );

    alias_fsm #(.ALIAS_W(ALIAS_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (req_valid),
        .action       (action),
        .stored_alias (dir_alias),
        .new_alias    (req_alias),
        .probe_ready  (probe_ready),
        .ack_valid    (ack_valid),
        .ack_dirty    (ack_dirty),
        .idle         (idle),
        .pass_now     (pass_now),
        .probe_valid  (probe_valid),
        .probe_alias  (probe_alias),
        .update       (update),
        .update_alias (dir_wr_alias),
        .dirty        (dirty)
    );

    always_comb begin
        req_ready    = idle;
        grant        = pass_now || update;
        dir_wr_valid = update;
        wb_need      = dirty;
    end

endmodule

// File: rtl/alias_resolver_chk.sv
module alias_resolver_chk #(
    parameter int ALIAS_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               req_hit,
    input logic               req_client,
    input logic [ALIAS_W-1:0] dir_alias,
    input logic [ALIAS_W-1:0] req_alias,
    input logic               grant,
    input logic               probe_valid,
    input logic               probe_ready,
    input logic [ALIAS_W-1:0] probe_alias,
    input logic               ack_valid,
    input logic               ack_dirty,
    input logic               dir_wr_valid,
    input logic [ALIAS_W-1:0] dir_wr_alias,
    input logic               wb_need
);

    p_match_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_hit && req_client && dir_alias == req_alias)
        |-> (grant && !dir_wr_valid && !probe_valid));

    p_probe_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(probe_valid) |-> (probe_alias == $past(dir_alias)));

    p_probe_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_valid && !probe_ready) |=> (probe_valid && $stable(probe_alias)));

    p_no_grant_in_probe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> (!grant && !dir_wr_valid));

    p_wb_with_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_need |-> dir_wr_valid);

    p_busy_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !dir_wr_valid) |-> !grant);

    p_idle_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr_valid |=> req_ready);

endmodule

bind alias_resolver alias_resolver_chk #(.ALIAS_W(ALIAS_W)) u_chk (.*);

// File: tb/sim_alias_resolver.sv
module sim_alias_resolver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_hit = 1'b0;
    logic       req_client = 1'b0;
    logic [1:0] dir_alias = 2'd0;
    logic [1:0] req_alias = 2'd0;
    logic       grant;
    logic       probe_valid;
    logic       probe_ready = 1'b0;
    logic [1:0] probe_alias;
    logic       ack_valid = 1'b0;
    logic       ack_dirty = 1'b0;
    logic       dir_wr_valid;
    logic [1:0] dir_wr_alias;
    logic       wb_need;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    alias_resolver u0 (.*);

    // vector: {hit, client, stored[1:0], acq[1:0], dirty, stall[1:0], exp_probe, exp_write, exp_wb}
    localparam logic [11:0] VEC [10] = '{
        {1'b1, 1'b1, 2'd2, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b1, 2'd0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 2'd1, 2'd3, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
        {1'b0, 1'b1, 2'd3, 2'd1, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0},
        {1'b0, 1'b0, 2'd0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
        {1'b1, 1'b1, 2'd1, 2'd2, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0},
        {1'b1, 1'b1, 2'd3, 2'd0, 1'b1, 2'd2, 1'b1, 1'b1, 1'b1},
        {1'b1, 1'b1, 2'd0, 2'd3, 1'b1, 2'd3, 1'b1, 1'b1, 1'b1},
        {1'b1, 1'b1, 2'd2, 2'd1, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0},
        {1'b1, 1'b0, 2'd2, 2'd2, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [11:0] v);
        logic       hit, cl, dty, ep, ew, eb;
        logic [1:0] st, aq, stall;
        {hit, cl, st, aq, dty, stall, ep, ew, eb} = v;
        @(negedge clk);
        req_valid = 1'b1; req_hit = hit; req_client = cl;
        dir_alias = st; req_alias = aq;
        #1;
        chk("R8 ready before request", int'(req_ready), 1);
        if (!ep && !ew) begin
            chk("R2 same-cycle grant", int'(grant), 1);
            chk("R2 no write", int'(dir_wr_valid), 0);
            @(negedge clk);
            req_valid = 1'b0; #1;
            chk("R2 stays idle", int'(req_ready), 1);
            chk("R2 no probe", int'(probe_valid), 0);
            return;
        end
        chk("R3 no grant yet", int'(grant), 0);
        @(negedge clk);
        req_valid = 1'b0; dir_alias = ~st; #1;
        if (ep) begin
            chk("R5 probe raised", int'(probe_valid), 1);
            chk("R5 probe alias", int'(probe_alias), int'(st));
            chk("R8 busy", int'(req_ready), 0);
            for (int i = 0; i < int'(stall); i++) begin
                @(negedge clk); #1;
                chk("R5 probe held", int'(probe_valid), 1);
                chk("R5 alias held", int'(probe_alias), int'(st));
            end
            probe_ready = 1'b1;
            @(negedge clk);
            probe_ready = 1'b0; #1;
            chk("R6 probe dropped", int'(probe_valid), 0);
            chk("R6 no grant before ack", int'(grant), 0);
            chk("R6 no write before ack", int'(dir_wr_valid), 0);
            @(negedge clk); #1;
            chk("R6 still waiting", int'(grant | dir_wr_valid), 0);
            ack_valid = 1'b1; ack_dirty = dty;
            @(negedge clk);
            ack_valid = 1'b0; ack_dirty = 1'b0; #1;
        end else begin
            chk(hit ? "R3 no probe" : "R4 no probe", int'(probe_valid), 0);
        end
        chk(ep ? "R6 write" : (hit ? "R3 write" : "R4 write"), int'(dir_wr_valid), 1);
        chk(ep ? "R6 new alias" : (hit ? "R3 new alias" : "R4 new alias"), int'(dir_wr_alias), int'(aq));
        chk(ep ? "R6 grant" : (hit ? "R3 grant" : "R4 grant"), int'(grant), 1);
        chk("R7 writeback flag", int'(wb_need), int'(eb));
        @(negedge clk); #1;
        chk("R7 flag clears", int'(wb_need | dir_wr_valid), 0);
        chk("R8 idle again", int'(req_ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ready", int'(req_ready), 0 + 1);
        chk("R1 grant", int'(grant), 0);
        chk("R1 probe", int'(probe_valid), 0);
        chk("R1 write", int'(dir_wr_valid | wb_need), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 idle after release", int'(req_ready), 1);

        for (int k = 0; k < 10; k++) run_vec(VEC[k]);

        // R9: stray dirty ack while idle, then a client-absent hit
        @(negedge clk);
        ack_valid = 1'b1; ack_dirty = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0; ack_dirty = 1'b0; #1;
        chk("R9 stray ack no write", int'(dir_wr_valid), 0);
        chk("R9 stray ack stays idle", int'(req_ready), 1);
        run_vec({1'b1, 1'b0, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0});

        // R8: request presented during a resolution is ignored
        @(negedge clk);
        req_valid = 1'b1; req_hit = 1'b1; req_client = 1'b1;
        dir_alias = 2'd0; req_alias = 2'd3;
        @(negedge clk);
        dir_alias = 2'd1; req_alias = 2'd1; #1;
        chk("R8 matching request while probing no grant", int'(grant), 0);
        chk("R8 not ready while probing", int'(req_ready), 0);
        probe_ready = 1'b1;
        @(negedge clk);
        probe_ready = 1'b0; #1;
        chk("R8 no grant while waiting", int'(grant), 0);
        req_valid = 1'b0;
        ack_valid = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0; #1;
        chk("R8 write keeps original alias", int'(dir_wr_alias), 3);
        @(negedge clk); #1;
        chk("R8 no phantom activity", int'(grant | probe_valid | dir_wr_valid), 0);
        chk("R8 idle at end", int'(req_ready), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule